// File: doc/BRIEF.md
# Memory-Card Slot Event Register Block

This block sits on a simple word-indexed register bus and watches two signals from a memory-card slot. The first is a write-protect level. The second is a card-insert strobe. It folds both into one interrupt status word. The write-protect bit follows its pin in the same cycle. The card-insert bit is a sticky flag: any cycle with the insert input high sets it, and it stays set after the input falls. Software clears it by writing a word with that bit set to the status index. The interrupt output is the sticky flag itself, so the output stays asserted until software acknowledges it.

Three more words sit next to the status word. One is an identification word that returns a build-time constant. The other two are placeholders that read zero and ignore writes. An index outside the four-word window raises an error strobe in the same cycle. Such an access reads zero and changes nothing.

Top module: `slot_event_regs`

## Requirements
- R1: While `rst` is high and after it falls, the card-insert flag (status bit 3) and `card_irq` are 0 until the insert input is seen high.
- R2: A read of index 0 returns the parameter `IDENT_WORD` in the same cycle.
- R3: Index 1 and index 3 read as zero. Writes to them are accepted with `err` low and change no register.
- R4: In a read of index 2, bit 0 equals `wp_in` in the same cycle, and every bit other than 0 and 3 is zero.
- R5: Status bit 3 is 1 in the cycle after any clock edge at which `card_in` is high. It stays 1 after `card_in` falls until it is cleared.
- R6: A write to index 2 whose data has bit 3 set clears status bit 3 at that clock edge. A write to index 2 with data bit 3 clear leaves it unchanged, whatever the other data bits are.
- R7: If `card_in` is high at the same edge as a clearing write, status bit 3 stays 1 because set wins over clear.
- R8: `card_irq` equals status bit 3 at all times. It falls in the cycle after a clearing write.
- R9: An access with index 4 or above drives `err` high in that cycle and reads zero. A write at such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Bus access valid this cycle |
| wr | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W (4) | Word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational, zero when not reading |
| err | output | 1 | Access to an index outside 0..3 |
| wp_in | input | 1 | Write-protect level from the slot |
| card_in | input | 1 | Card-insert strobe from the slot |
| card_irq | output | 1 | Interrupt, high while the sticky insert flag is set |

## Verification
The only internal state is the sticky insert flag. If that flag is wrong, it shows at the ports in two ways: as `card_irq` one cycle after the offending edge, and as bit 3 of a status read in that same cycle. The bench therefore checks both, right after every edge that can set or clear the flag. A decode fault shows at once as nonzero data or a wrong `err` on the access itself. A stray write shows on the next status read.

// File: rtl/slot_event_pkg.sv
package slot_event_pkg;

    localparam int WP_POS   = 0;
    localparam int CARD_POS = 3;
    localparam int N_WORDS  = 4;

    typedef enum logic [1:0] {
        IX_IDENT  = 2'd0,
        IX_FPROG  = 2'd1,
        IX_STATUS = 2'd2,
        IX_DECODE = 2'd3
    } word_ix_e;

    typedef struct packed {
        logic ident;
        logic fprog;
        logic status;
        logic decode;
        logic bad;
    } word_sel_t;

    function automatic logic [31:0] bit_mask(input int pos);
        logic [31:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/slot_event_decode.sv
module slot_event_decode
    import slot_event_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output word_sel_t         sel
);
    logic [N_WORDS-1:0] hit;

    for (genvar i = 0; i < N_WORDS; i++) begin : g_hit
        assign hit[i] = req && (addr == ADDR_W'(i));
    end

    always_comb begin
        sel.ident  = hit[IX_IDENT];
        sel.fprog  = hit[IX_FPROG];
        sel.status = hit[IX_STATUS];
        sel.decode = hit[IX_DECODE];
        sel.bad    = req && (hit == '0);
    end
endmodule

// File: rtl/slot_event_status.sv
module slot_event_status
    import slot_event_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_in,
    input  logic              card_in,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] status_word,
    output logic              card_flag
);
    localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(bit_mask(CARD_POS));

    logic clr_hit;
    assign clr_hit = clr_stb && ((clr_data & CARD_MASK) != '0);

    always_ff @(posedge clk) begin
        if (rst)          card_flag <= 1'b0;
        else if (card_in) card_flag <= 1'b1;
        else if (clr_hit) card_flag <= 1'b0;
    end

    always_comb begin
        status_word           = '0;
        status_word[WP_POS]   = wp_in;
        status_word[CARD_POS] = card_flag;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !card_flag);
    // R5
    a_r5_sets: assert property (@(posedge clk) disable iff (rst)
        card_in |=> card_flag);
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (card_flag && !(clr_stb && clr_data[CARD_POS])) |=> card_flag);
    // R6
    a_r6_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && clr_data[CARD_POS] && !card_in) |=> !card_flag);
    // R7
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && card_in) |=> card_flag);
endmodule

// File: rtl/slot_event_rdmux.sv
module slot_event_rdmux
    import slot_event_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] IDENT_WORD = '0
) (
    input  word_sel_t         sel,
    input  logic              rd,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (1'b1)
                sel.ident:  rdata = IDENT_WORD;
                sel.status: rdata = status_word;
                sel.fprog,
                sel.decode,
                sel.bad:    rdata = '0;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/slot_event_regs.sv
module slot_event_regs
    import slot_event_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 4,
    parameter logic [DATA_W-1:0] IDENT_WORD = 32'h5C0D_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              card_irq
);
    word_sel_t         sel;
    logic [DATA_W-1:0] status_word;
    logic              card_flag;

    slot_event_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req  (req),
        .addr (addr),
        .sel  (sel)
    );

    slot_event_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst         (rst),
        .wp_in       (wp_in),
        .card_in     (card_in),
        .clr_stb     (sel.status && wr),
        .clr_data    (wdata),
        .status_word (status_word),
        .card_flag   (card_flag)
    );

    slot_event_rdmux #(.DATA_W(DATA_W), .IDENT_WORD(IDENT_WORD)) u_rdmux (
        .sel         (sel),
        .rd          (!wr),
        .status_word (status_word),
        .rdata       (rdata)
    );

    assign err      = sel.bad;
    assign card_irq = card_flag;

    // R2
    a_r2_ident: assert property (@(posedge clk) disable iff (rst)
        (req && !wr && addr == ADDR_W'(0)) |-> rdata == IDENT_WORD);
    // R4
    a_r4_wp_live: assert property (@(posedge clk) disable iff (rst)
        (req && !wr && addr == ADDR_W'(2)) |-> rdata[WP_POS] == wp_in);
    // R8
    a_r8_irq_matches: assert property (@(posedge clk) disable iff (rst)
        (req && !wr && addr == ADDR_W'(2)) |-> rdata[CARD_POS] == card_irq);
    // R9
    a_r9_bad_reads_zero: assert property (@(posedge clk) disable iff (rst)
        err |-> rdata == '0);
endmodule

// File: tb/slot_event_regs_tb.sv
module slot_event_regs_tb;
    localparam logic [31:0] ID = 32'h5C0D_0100;

    logic        clk = 0;
    logic        rst = 1;
    logic        req = 0, wr = 0, wp_in = 0, card_in = 0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err, card_irq;
    int          checks = 0, errors = 0;

    always #10 clk = ~clk;

    slot_event_regs u_dut (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .wp_in(wp_in),
        .card_in(card_in), .card_irq(card_irq)
    );

    // vector: card, wp, addr[3:0], wdata[31:0], exp_status[31:0], exp_irq
    localparam int NV = 9;
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd15, 32'h0,        32'h1, 1'b0}, // R4 no write
        {1'b1, 1'b0, 4'd15, 32'h0,        32'h8, 1'b1}, // R5 set
        {1'b0, 1'b1, 4'd2,  32'h1,        32'h9, 1'b1}, // R6 bit3 clear no effect
        {1'b0, 1'b0, 4'd1,  32'hFFFFFFFF, 32'h8, 1'b1}, // R3 placeholder write
        {1'b0, 1'b0, 4'd2,  32'h8,        32'h0, 1'b0}, // R6 clear
        {1'b1, 1'b1, 4'd2,  32'hFFFFFFFF, 32'h9, 1'b1}, // R7 set wins
        {1'b0, 1'b1, 4'd7,  32'hFFFFFFFF, 32'h9, 1'b1}, // R9 bad write
        {1'b0, 1'b0, 4'd2,  32'hFFFFFFF7, 32'h8, 1'b1}, // R6 other bits ignored
        {1'b0, 1'b0, 4'd3,  32'hFFFFFFFF, 32'h8, 1'b1}  // R3 decode write
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_at(input logic [3:0] a);
        req = 1; wr = 0; addr = a; #1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rd_at(4'd2);
        chk("R1 status in reset", rdata, 32'h0);
        chk("R1 irq in reset", {31'b0, card_irq}, 32'h0);
        rst = 0;
        @(negedge clk);
        rd_at(4'd2);
        chk("R1 status after reset", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            card_in = VEC[i][70]; wp_in = VEC[i][69];
            if (VEC[i][68:65] == 4'd15) begin
                req = 0; wr = 0;
            end else begin
                req = 1; wr = 1; addr = VEC[i][68:65]; wdata = VEC[i][64:33];
            end
            @(negedge clk);
            card_in = 0;
            rd_at(4'd2);
            chk($sformatf("R5/R6 vec%0d status", i), rdata, VEC[i][32:1]);
            chk($sformatf("R8 vec%0d irq", i), {31'b0, card_irq}, {31'b0, VEC[i][0]});
        end

        @(negedge clk);
        rd_at(4'd0);
        chk("R2 ident", rdata, ID);
        chk("R2 no err", {31'b0, err}, 32'h0);
        rd_at(4'd1);
        chk("R3 index1 zero", rdata, 32'h0);
        rd_at(4'd3);
        chk("R3 index3 zero", rdata, 32'h0);
        req = 1; wr = 1; addr = 4'd3; #1;
        chk("R3 write err low", {31'b0, err}, 32'h0);
        rd_at(4'd9);
        chk("R9 bad read zero", rdata, 32'h0);
        chk("R9 bad read err", {31'b0, err}, 32'h1);
        wp_in = 1; rd_at(4'd2);
        chk("R4 wp live", rdata, 32'h9);
        wp_in = 0; #1;
        chk("R4 wp live fall", rdata, 32'h8);
        chk("R9 err low on status", {31'b0, err}, 32'h0);
        req = 0; #1;
        chk("rdata idle zero", rdata, 32'h0);

        @(negedge clk);
        req = 1; wr = 1; addr = 4'd2; wdata = 32'h8;
        @(negedge clk);
        rd_at(4'd2);
        chk("R8 irq falls after clear", {31'b0, card_irq}, 32'h0);
        req = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule